// File: doc/BRIEF.md
# Receive Engine with Destination Address Filter

This block sits on the receive side of a gigabit Ethernet MAC. Its input is a byte-wide stream from the physical layer, qualified by a data-valid strobe and an error strobe. Before the start-of-frame delimiter (0xD5) it discards every byte. After that byte it collects the six destination-address bytes. The assembled address is then compared against a small table that the management logic writes.

Frames addressed to a valid table entry are handed to the client one byte per cycle. So are broadcast frames, and every frame when the promiscuous input is set. All other frames vanish without a trace. The address bytes are held in a six-stage delay line until the decision is made, so the client sees an accepted frame from its first destination byte through the last frame check byte. On that last byte the block reports whether the frame was good or bad. A frame is bad if its CRC32 check fails, if an error was flagged on any of its bytes, or if it is shorter than the minimum frame length.

Top module: `mac_rx_filter`

## Requirements
- R1: Bytes are ignored until a byte equal to 0xD5 is sampled while `gm_dv` is high. A `gm_dv` burst that ends before such a byte produces no client byte and no status pulse, whatever the burst length (1 to 7 or more bytes).
- R2: The first address byte received after 0xD5 is compared with bits [47:40] of a table entry and the sixth with bits [7:0]. Entry i occupies `tbl_mac[48*i+47 : 48*i]`. A frame whose address equals a valid entry in all six bytes is accepted. A difference in any single byte rejects it, unless R4 or R5 applies.
- R3: An entry whose `tbl_vld` bit is 0 never matches. A rejected frame produces no `cli_valid` and no status pulse.
- R4: The destination FF:FF:FF:FF:FF:FF is accepted whatever the table holds.
- R5: While `promisc` is 1, every frame is accepted.
- R6: An accepted frame appears on `cli_data`/`cli_valid` in order, one byte per cycle, from the first destination byte through the last check byte. If the first destination byte is sampled at clock edge k, it is presented in the cycle after edge k+5. `cli_last` marks the final byte.
- R7: Each accepted frame that reaches its sixth address byte gives exactly one pulse of `frm_good` or `frm_bad`, in the cycle of `cli_last`. Neither pulses at any other time.
- R8: A frame is bad when the CRC32 check fails. The CRC uses reflected polynomial 0xEDB88320 and starts from all ones. It runs over every byte from the destination address through the check field, least significant bit first. The check fails if the remainder is not 0xDEBB20E3.
- R9: A frame is bad when `gm_err` is high on any byte sampled after 0xD5, including the first destination byte.
- R10: A frame is bad when it holds fewer than `MIN_FRAME` (64) bytes from destination through check field. At 64 bytes or more, with R8 and R9 satisfied, it is good.
- R11: A frame whose `gm_dv` drops before its sixth address byte produces no client byte and no status pulse.
- R12: During and right after reset, `cli_valid`, `cli_last`, `frm_good` and `frm_bad` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gm_dv | input | 1 | Received byte is valid |
| gm_byte | input | 8 | Received byte |
| gm_err | input | 1 | Receive error flag for the current byte |
| tbl_mac | input | 48*N_ENTRIES | Address table, entry i at bits 48*i+47 down to 48*i |
| tbl_vld | input | N_ENTRIES | Per-entry valid bits |
| promisc | input | 1 | Accept every frame |
| cli_data | output | 8 | Byte to the client |
| cli_valid | output | 1 | `cli_data` carries a frame byte |
| cli_last | output | 1 | Final byte of the frame |
| frm_good | output | 1 | Frame passed all checks (with `cli_last`) |
| frm_bad | output | 1 | Frame failed a check (with `cli_last`) |

## Verification
The bench builds the block with its defaults: four table entries with entry 2 left invalid, and a 64-byte minimum. Four entries are few enough to visit every entry, the invalid one, and a one-byte miss at each of the six address positions. Lengths are swept from 60 to 68 bytes so that the 64-byte boundary is crossed in both directions. The sweeps also cover every preamble length from 1 to 7, every runt length from 1 to 5, and error and CRC faults on top of accepted frames, with the expected bytes, latency and status computed in the bench.

// File: rtl/mac_rx_pkg.sv
package mac_rx_pkg;
  localparam int          DA_BYTES   = 6;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESID  = 32'hDEBB_20E3;

  typedef enum logic [1:0] {S_PRE, S_ADDR, S_PASS, S_DROP} rx_state_t;

  typedef struct packed {
    logic       vld;
    logic [7:0] data;
  } lane_t;

  // One byte through the reflected CRC32, byte-xor then eight shifts.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic judge_bad(input logic crc_ok, input logic err, input logic short_frm);
    return !crc_ok || err || short_frm;
  endfunction
endpackage

// File: rtl/mac_rx_crc.sv
module mac_rx_crc
  import mac_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] data,
  output logic       crc_ok
);
  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= CRC_SEED;
    else if (clr) crc_q <= CRC_SEED;
    else if (en)  crc_q <= crc_step(crc_q, data);
  end

  assign crc_ok = (crc_q == CRC_RESID);
endmodule

// File: rtl/mac_rx_match.sv
module mac_rx_match #(
  parameter int N_ENTRIES = 4
) (
  input  logic [47:0]             da,
  input  logic [N_ENTRIES*48-1:0] tbl_mac,
  input  logic [N_ENTRIES-1:0]    tbl_vld,
  input  logic                    promisc,
  output logic                    hit
);
  logic [N_ENTRIES-1:0] ent_hit;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    assign ent_hit[i] = tbl_vld[i] && (tbl_mac[i*48 +: 48] == da);
  end

  assign hit = promisc || (&da) || (|ent_hit);
endmodule

// File: rtl/mac_rx_delay.sv
module mac_rx_delay
  import mac_rx_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_data,
  output logic       out_vld,
  output logic [7:0] out_data,
  output logic       prev_vld
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_st
    lane_t q;
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= '{vld: in_vld, data: in_data};
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_st[k-1].q;
      end
    end
  end

  assign out_vld  = g_st[DEPTH-1].q.vld;
  assign out_data = g_st[DEPTH-1].q.data;
  assign prev_vld = g_st[DEPTH-2].q.vld;
endmodule

// File: rtl/mac_rx_filter.sv
module mac_rx_filter
  import mac_rx_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int MIN_FRAME = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gm_dv,
  input  logic [7:0]              gm_byte,
  input  logic                    gm_err,
  input  logic [N_ENTRIES*48-1:0] tbl_mac,
  input  logic [N_ENTRIES-1:0]    tbl_vld,
  input  logic                    promisc,
  output logic [7:0]              cli_data,
  output logic                    cli_valid,
  output logic                    cli_last,
  output logic                    frm_good,
  output logic                    frm_bad
);
  localparam int LEN_W = $clog2(MIN_FRAME + 1);
  localparam int IDX_W = $clog2(DA_BYTES);

  rx_state_t        st;
  logic [IDX_W-1:0] da_idx;
  logic [39:0]      da_q;
  logic [47:0]      da_next;
  logic [LEN_W-1:0] len_q;
  logic             err_q, accept_q, bad_q;
  logic             hit, crc_ok, dl_vld, dl_prev;
  logic [7:0]       dl_data;

  // Named internal events, also watched by the checker.
  logic push, ev_sfd, ev_decide, ev_accept, ev_end;
  assign ev_sfd    = (st == S_PRE) && gm_dv && (gm_byte == SFD_BYTE);
  assign push      = gm_dv && (st != S_PRE);
  assign da_next   = {da_q, gm_byte};
  assign ev_decide = push && (st == S_ADDR) && (da_idx == IDX_W'(DA_BYTES - 1));
  assign ev_accept = ev_decide && hit;
  assign ev_end    = !gm_dv && ((st == S_PASS) || (st == S_DROP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PRE;
    end else begin
      unique case (st)
        S_PRE:  if (ev_sfd) st <= S_ADDR;
        S_ADDR: if (!gm_dv) st <= S_PRE;
                else if (ev_decide) st <= hit ? S_PASS : S_DROP;
        default: if (!gm_dv) st <= S_PRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_idx   <= '0;
      da_q     <= '0;
      len_q    <= '0;
      err_q    <= 1'b0;
      accept_q <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      if (ev_sfd) begin
        da_idx   <= '0;
        len_q    <= '0;
        err_q    <= 1'b0;
        accept_q <= 1'b0;
      end else begin
        if (push && st == S_ADDR) begin
          da_idx <= da_idx + 1'b1;
          da_q   <= da_next[39:0];
        end
        if (push && len_q < LEN_W'(MIN_FRAME)) len_q <= len_q + 1'b1;
        if (push && gm_err) err_q <= 1'b1;
        if (ev_accept) accept_q <= 1'b1;
      end
      if (ev_end) bad_q <= judge_bad(crc_ok, err_q, len_q < LEN_W'(MIN_FRAME));
    end
  end

  mac_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(ev_sfd), .en(push), .data(gm_byte), .crc_ok(crc_ok)
  );

  mac_rx_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .da(da_next), .tbl_mac(tbl_mac), .tbl_vld(tbl_vld), .promisc(promisc), .hit(hit)
  );

  mac_rx_delay #(.DEPTH(DA_BYTES)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_vld(push), .in_data(gm_byte),
    .out_vld(dl_vld), .out_data(dl_data), .prev_vld(dl_prev)
  );

  assign cli_data  = dl_data;
  assign cli_valid = dl_vld && accept_q;
  assign cli_last  = cli_valid && !dl_prev;
  assign frm_good  = cli_last && !bad_q;
  assign frm_bad   = cli_last && bad_q;
endmodule

// File: rtl/mac_rx_filter_chk.sv
module mac_rx_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cli_valid,
  input logic        cli_last,
  input logic        frm_good,
  input logic        frm_bad,
  input logic        promisc,
  input logic        ev_sfd,
  input logic        ev_decide,
  input logic        ev_accept,
  input logic [47:0] da_next
);
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n) !(frm_good && frm_bad)); // R7
  AST_STATUS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n) (frm_good || frm_bad) |-> cli_last); // R7
  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n) cli_last |-> cli_valid); // R6
  AST_QUIET_AFTER_SFD: assert property (@(posedge clk) disable iff (!rst_n) ev_sfd |=> !cli_valid); // R6
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (ev_decide && !ev_accept) |=> !cli_valid); // R3
  AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (ev_decide && (&da_next)) |-> ev_accept); // R4
  AST_PROMISC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (ev_decide && promisc) |-> ev_accept); // R5
endmodule

bind mac_rx_filter mac_rx_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cli_valid(cli_valid), .cli_last(cli_last),
  .frm_good(frm_good), .frm_bad(frm_bad), .promisc(promisc),
  .ev_sfd(ev_sfd), .ev_decide(ev_decide), .ev_accept(ev_accept), .da_next(da_next)
);

// File: tb/mac_rx_filter_tb.sv
module mac_rx_filter_tb;
  localparam int N    = 4;
  localparam int MINF = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic dv = 1'b0, err = 1'b0, promisc = 1'b0;
  logic [7:0] byt = 8'h00;
  logic [N*48-1:0] tmac;
  logic [N-1:0] tvld;
  logic [7:0] cli_data;
  logic cli_valid, cli_last, frm_good, frm_bad;

  mac_rx_filter #(.N_ENTRIES(N), .MIN_FRAME(MINF)) u_dut (
    .clk(clk), .rst_n(rst_n), .gm_dv(dv), .gm_byte(byt), .gm_err(err),
    .tbl_mac(tmac), .tbl_vld(tvld), .promisc(promisc),
    .cli_data(cli_data), .cli_valid(cli_valid), .cli_last(cli_last),
    .frm_good(frm_good), .frm_bad(frm_bad)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, da_cyc = 0, first_cyc = -1;
  int got_good = 0, got_bad = 0, stray = 0;
  logic [7:0] got[$];
  logic [7:0] fr[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cli_valid) begin
      if (got.size() == 0) first_cyc = cyc;
      got.push_back(cli_data);
    end
    if (frm_good) got_good++;
    if (frm_bad) got_bad++;
    if ((frm_good || frm_bad) && !cli_last) stray++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bit-serial CRC, written independently of the byte-wise form.
  function automatic logic [31:0] tb_crc(input int upto);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < upto; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ fr[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return c;
  endfunction

  function automatic bit tb_accept(input logic [47:0] da);
    bit a = promisc || (da == 48'hFFFF_FFFF_FFFF);
    for (int i = 0; i < N; i++)
      if (tvld[i] && tmac[i*48 +: 48] == da) a = 1;
    return a;
  endfunction

  task automatic build(input logic [47:0] da, input int len, input bit corrupt);
    logic [31:0] c;
    fr.delete();
    for (int i = 5; i >= 0; i--) fr.push_back(da[i*8 +: 8]);
    for (int i = 0; i < 6; i++) fr.push_back(8'h02 + 8'(i));
    while (fr.size() < len - 4) fr.push_back(8'(fr.size() * 7 + 3));
    c = ~tb_crc(fr.size());
    for (int i = 0; i < 4; i++) fr.push_back(c[i*8 +: 8]);
    if (corrupt) fr[fr.size()-1] = fr[fr.size()-1] ^ 8'h01;
  endtask

  // Drive preamble, optional SFD and fr[]; err_at selects a byte of fr[].
  task automatic send(input int pre, input bit with_sfd, input int err_at);
    got.delete(); got_good = 0; got_bad = 0; stray = 0; first_cyc = -1;
    for (int i = 0; i < pre; i++) begin
      @(negedge clk); dv = 1; byt = 8'h55;
    end
    if (with_sfd) begin
      @(negedge clk); dv = 1; byt = 8'hD5;
      for (int i = 0; i < fr.size(); i++) begin
        @(negedge clk); byt = fr[i]; err = (i == err_at);
        if (i == 0) da_cyc = cyc + 1;
      end
    end
    @(negedge clk); dv = 0; err = 0; byt = 8'h00;
    repeat (14) @(negedge clk);
  endtask

  task automatic run_frame(input string req, input logic [47:0] da, input int len,
                           input int pre, input bit corrupt, input int err_at);
    bit acc, bad;
    int diff;
    build(da, len, corrupt);
    send(pre, 1, err_at);
    acc = tb_accept(da);
    bad = corrupt || (err_at >= 0) || (len < MINF);
    if (acc) begin
      chk(req, "accepted byte count", got.size(), len);
      diff = 0;
      for (int i = 0; i < got.size() && i < len; i++) if (got[i] !== fr[i]) diff++;
      chk("R6", "byte mismatches", diff, 0);
      chk("R6", "latency", first_cyc - da_cyc, 5);
      chk(bad ? req : "R7", "frm_bad pulses", got_bad, int'(bad));
      chk(bad ? req : "R7", "frm_good pulses", got_good, int'(!bad));
      chk("R7", "status off last", stray, 0);
    end else begin
      chk(req, "dropped byte count", got.size(), 0);
      chk(req, "dropped status", got_good + got_bad, 0);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 60000) begin
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    finish_run();
  end

  initial begin
    logic [47:0] e0;
    tmac = {48'h0A_BC_DE_F0_12_34, 48'h06_00_00_00_00_07, 48'h02_AA_BB_CC_DD_EE, 48'h02_11_22_33_44_55};
    tvld = 4'b1011;
    e0 = tmac[47:0];
    repeat (3) @(negedge clk);
    chk("R12", "valid in reset", int'(cli_valid), 0);
    chk("R12", "status in reset", int'(frm_good) + int'(frm_bad) + int'(cli_last), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "valid after reset", int'(cli_valid), 0);

    for (int i = 0; i < N; i++)
      run_frame(i == 2 ? "R3" : "R2", tmac[i*48 +: 48], 72, 7, 0, -1);
    run_frame("R3", 48'h02_99_88_77_66_55, 70, 7, 0, -1);
    for (int k = 0; k < 6; k++)
      run_frame("R2", e0 ^ (48'h01 << (8*k)), 70, 7, 0, -1);
    run_frame("R4", 48'hFFFF_FFFF_FFFF, 64, 7, 0, -1);
    promisc = 1;
    run_frame("R5", 48'h02_99_88_77_66_55, 66, 7, 0, -1);
    promisc = 0;
    run_frame("R8", e0, 80, 7, 1, -1);
    run_frame("R9", e0, 80, 7, 0, 20);
    run_frame("R9", e0, 80, 7, 0, 0);
    for (int len = 60; len <= 68; len++)
      run_frame("R10", e0, len, 7, 0, -1);
    for (int p = 1; p <= 7; p++)
      run_frame("R1", tmac[48 +: 48], 64, p, 0, -1);
    for (int p = 1; p <= 7; p++) begin
      send(p, 0, -1);
      chk("R1", "bytes without SFD", got.size(), 0);
      chk("R1", "status without SFD", got_good + got_bad, 0);
    end
    for (int n = 1; n <= 5; n++) begin
      fr.delete();
      for (int i = 0; i < n; i++) fr.push_back(e0[(5-i)*8 +: 8]);
      send(7, 1, -1);
      chk("R11", "runt bytes", got.size(), 0);
      chk("R11", "runt status", got_good + got_bad, 0);
    end
    finish_run();
  end
endmodule